// File: doc/BRIEF.md
# On-Screen-Display Window Column Timing Generator

This block places one rectangular overlay window on a video raster and tells the character pipeline behind it where it stands. It counts pixel clocks from the rising edge of the horizontal flyback input and counts lines from the rising edge of vertical sync. It then raises a line-level window flag and a per-pixel valid strobe. While the strobe is high it outputs the current character column and the font pixel index inside that column.

The left edge comes from an 8-bit horizontal register that is scaled by four and offset by thirty pixels. Values that are too small to be safe are clamped and flagged. The top edge comes from an 8-bit vertical register scaled by two lines. A 32-bit mask makes each of the first 32 columns either normal width or double width. In a double-width column every font pixel is repeated on two consecutive clocks. All register inputs are sampled once per line, at the flyback rising edge, so a change never splits a row.

Top module: `osd_window_timing`

## Requirements
- R1: After reset, win_active, pix_valid, col_idx, font_x, line_in_win and hstart_bad are all 0.
- R2: If hflyback is first sampled high at clock edge E, that cycle is pixel position 0 of the line. pix_valid first rises in the cycle at pixel position 4*H+30, where H is the sampled hstart, and col_idx=0 and font_x=0 in that cycle.
- R3: A sampled hstart of 0, 1 or 2 is treated as 3, so the window starts at position 42, and hstart_bad reads 1 for that line. For any larger value hstart_bad reads 0.
- R4: Lines are numbered from 0, where line 0 is the first flyback rise after a vsync rise. win_active is 1 for line L exactly when 2*V <= L < 2*V+WIN_LINES, with V the vstart value sampled at that line's flyback rise. pix_valid is never 1 while win_active is 0.
- R5: In a normal column, font_x steps 0,1,...,11 on consecutive clocks, so the column lasts 12 pixels.
- R6: In column c < 32 with wide_mask bit c = 1, each font_x value is held for two clocks, so the column lasts 24 pixels.
- R7: Columns with index 32 or higher are always 12 pixels wide, whatever the mask holds.
- R8: After column NUM_COLS-1 has ended, pix_valid stays 0 until the next line.
- R9: Changes to hstart, vstart and wide_mask made during a line have no effect until the next flyback rise.
- R10: line_in_win equals L-2*V while win_active is 1, and 0 otherwise.
- R11: If vsync and hflyback rise on the same clock edge, that line is line 0 of the new frame.
- R12: A flyback rise while the window is running ends the window at once. The new line starts again at column 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hflyback | input | 1 | Horizontal flyback pulse; the rising edge starts a line |
| vsync | input | 1 | Vertical sync; the rising edge starts a frame |
| hstart | input | 8 | Horizontal start code (pixels = 4*code+30) |
| vstart | input | 8 | Vertical start code (lines = 2*code) |
| wide_mask | input | 32 | Bit c selects double width for column c |
| win_active | output | 1 | Current line lies inside the window |
| pix_valid | output | 1 | Current pixel lies inside the window |
| col_idx | output | 6 | Current character column |
| font_x | output | 4 | Font pixel index inside the column, 0 to 11 |
| line_in_win | output | 10 | Line index relative to the window top |
| hstart_bad | output | 1 | Sampled hstart was below the legal minimum and was clamped |

## Verification
Two events can land on the same clock edge: the vsync rise that resets the line count, and the flyback rise that advances it. The bench first moves the line count past the bottom of the window. It then raises both inputs together and expects win_active=1 with line_in_win=0. A design that applies the increment after the reset, or ignores the reset, reports a line outside the window. The same kind of collision is provoked on the horizontal side: a flyback arrives in the middle of a running window, and the bench checks that the valid strobe drops at once and restarts at column 0.

// File: rtl/osd_window_timing.sv
module osd_window_timing #(
  parameter int NUM_COLS  = 40,
  parameter int FONT_W    = 12,
  parameter int WIN_LINES = 4,
  parameter int LINE_W    = 10,
  parameter int HCNT_W    = 12,
  parameter int MASK_W    = 32,
  localparam int COL_W    = (NUM_COLS > 1) ? $clog2(NUM_COLS) : 1,
  localparam int FX_W     = $clog2(FONT_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hflyback,
  input  logic              vsync,
  input  logic [7:0]        hstart,
  input  logic [7:0]        vstart,
  input  logic [MASK_W-1:0] wide_mask,
  output logic              win_active,
  output logic              pix_valid,
  output logic [COL_W-1:0]  col_idx,
  output logic [FX_W-1:0]   font_x,
  output logic [LINE_W-1:0] line_in_win,
  output logic              hstart_bad
);

  localparam int MEXT_W = 1 << COL_W;

  logic              fb_q, vs_q;
  logic [HCNT_W-1:0] hcnt, hs_px;
  logic [7:0]        vs_lat;
  logic [MASK_W-1:0] mask_lat;
  logic [LINE_W-1:0] line_cnt;
  logic              vin, run, ph, bad;
  logic [COL_W-1:0]  col;
  logic [FX_W-1:0]   fx;

  logic              fb_rise, vs_rise, start, dbl, last_fx, last_col;
  logic [7:0]        hs_eff;
  logic [HCNT_W-1:0] hs_px_in;
  logic [LINE_W-1:0] line_nxt, vbase_in, vbase_lat;
  logic [MEXT_W-1:0] mask_ext;

  assign fb_rise   = hflyback & ~fb_q;
  assign vs_rise   = vsync & ~vs_q;
  assign hs_eff    = (hstart <= 8'd2) ? 8'd3 : hstart;
  assign hs_px_in  = HCNT_W'(hs_eff) * HCNT_W'(4) + HCNT_W'(30);
  assign vbase_in  = LINE_W'({vstart, 1'b0});
  assign vbase_lat = LINE_W'({vs_lat, 1'b0});
  assign line_nxt  = vs_rise ? '0 : line_cnt + 1'b1;
  assign start     = !fb_rise && !vs_rise && vin && (hcnt == hs_px - 1'b1);
  assign mask_ext  = MEXT_W'(mask_lat);
  assign dbl       = mask_ext[col];
  assign last_fx   = (fx == FX_W'(FONT_W - 1));
  assign last_col  = (col == COL_W'(NUM_COLS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fb_q <= 1'b0;
      vs_q <= 1'b0;
    end else begin
      fb_q <= hflyback;
      vs_q <= vsync;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                hcnt <= '0;
    else if (fb_rise)          hcnt <= '0;
    else if (hcnt != '1)       hcnt <= hcnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_cnt <= '0;
      vin      <= 1'b0;
      hs_px    <= '0;
      vs_lat   <= '0;
      mask_lat <= '0;
      bad      <= 1'b0;
    end else if (fb_rise) begin
      line_cnt <= line_nxt;
      vin      <= (line_nxt >= vbase_in) && (line_nxt < vbase_in + LINE_W'(WIN_LINES));
      hs_px    <= hs_px_in;
      vs_lat   <= vstart;
      mask_lat <= wide_mask;
      bad      <= (hstart <= 8'd2);
    end else if (vs_rise) begin
      line_cnt <= '1;
      vin      <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run <= 1'b0;
      col <= '0;
      fx  <= '0;
      ph  <= 1'b0;
    end else if (fb_rise || vs_rise) begin
      run <= 1'b0;
      col <= '0;
      fx  <= '0;
      ph  <= 1'b0;
    end else if (start) begin
      run <= 1'b1;
      col <= '0;
      fx  <= '0;
      ph  <= 1'b0;
    end else if (run) begin
      if (dbl && !ph) begin
        ph <= 1'b1;
      end else begin
        ph <= 1'b0;
        if (last_fx) begin
          fx <= '0;
          if (last_col) begin
            run <= 1'b0;
            col <= '0;
          end else begin
            col <= col + 1'b1;
          end
        end else begin
          fx <= fx + 1'b1;
        end
      end
    end
  end

  assign win_active  = vin;
  assign pix_valid   = run;
  assign col_idx     = col;
  assign font_x      = fx;
  assign line_in_win = vin ? (line_cnt - vbase_lat) : '0;
  assign hstart_bad  = bad;

  assert_fx_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    fx <= FX_W'(FONT_W - 1));

  assert_valid_in_window_R4: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid |-> win_active);

  assert_col_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid |-> (int'(col_idx) < NUM_COLS));

  assert_start_origin_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pix_valid) |-> (col_idx == '0 && font_x == '0));

  assert_min_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pix_valid) |-> (hcnt >= HCNT_W'(42)));

  assert_high_cols_narrow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && $past(pix_valid) && col_idx == $past(col_idx) && int'(col_idx) >= 32)
      |-> font_x == FX_W'($past(font_x) + 1'b1));

endmodule

// File: tb/osd_window_timing_tb.sv
module osd_window_timing_tb;

  localparam int NCOL = 40;
  localparam int WL   = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        hflyback = 1'b0;
  logic        vsync = 1'b0;
  logic [7:0]  hstart = 8'd3;
  logic [7:0]  vstart = 8'd0;
  logic [31:0] wide_mask = '0;
  logic        win_active, pix_valid, hstart_bad;
  logic [5:0]  col_idx;
  logic [3:0]  font_x;
  logic [9:0]  line_in_win;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #2.5 clk = ~clk;

  osd_window_timing #(.NUM_COLS(NCOL), .WIN_LINES(WL)) u_dut (
    .clk(clk), .rst_n(rst_n), .hflyback(hflyback), .vsync(vsync),
    .hstart(hstart), .vstart(vstart), .wide_mask(wide_mask),
    .win_active(win_active), .pix_valid(pix_valid), .col_idx(col_idx),
    .font_x(font_x), .line_in_win(line_in_win), .hstart_bad(hstart_bad)
  );

  // {hstart, wide_mask}
  localparam logic [39:0] VEC [0:5] = '{
    {8'd3,  32'h0000_0000},
    {8'd10, 32'hFFFF_FFFF},
    {8'd0,  32'hA5A5_0F0F},
    {8'd2,  32'h8000_0001},
    {8'd25, 32'h0000_FF00},
    {8'd1,  32'h5555_5555}
  };

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic pulse_fb();
    @(negedge clk) hflyback = 1'b1;
    @(negedge clk) hflyback = 1'b0;
  endtask

  task automatic pulse_vs();
    @(negedge clk) vsync = 1'b1;
    @(negedge clk) vsync = 1'b0;
  endtask

  function automatic int col_w(input int c, input logic [31:0] m);
    return (c < 32 && m[c]) ? 24 : 12;
  endfunction

  function automatic int line_total(input logic [31:0] m);
    int t = 0;
    for (int c = 0; c < NCOL; c++) t += col_w(c, m);
    return t;
  endfunction

  function automatic int exp_pos(input int p, input logic [31:0] m);
    int r = p;
    for (int c = 0; c < NCOL; c++) begin
      if (r < col_w(c, m))
        return c * 16 + ((col_w(c, m) == 24) ? r / 2 : r);
      r -= col_w(c, m);
    end
    return 0;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_tests++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!win_active && !pix_valid && col_idx == 0 && font_x == 0 &&
        line_in_win == 0 && !hstart_bad, "R1 reset outputs", int'(pix_valid), 0);
    rst_n = 1'b1;

    // table walk: horizontal start, clamp, column widths, end of row
    for (int v = 0; v < 6; v++) begin
      logic [7:0]  h;
      logic [31:0] m;
      int s, tot, e_start, e_body, e_end, pos;
      h = VEC[v][39:32];
      m = VEC[v][31:0];
      s = ((h <= 2) ? 3 : int'(h)) * 4 + 30;
      tot = line_total(m);
      e_start = 0; e_body = 0; e_end = 0;
      hstart = h; wide_mask = m; vstart = 8'd0;
      pulse_vs();
      pulse_fb();
      // R9: garbage during the line must not matter
      hstart = 8'd60; wide_mask = ~m; vstart = 8'd100;
      chk(hstart_bad == (h <= 2), "R3 clamp flag", int'(hstart_bad), int'(h <= 2));
      for (int k = 0; k < s + tot + 4; k++) begin
        if (k <= s) begin
          if (pix_valid != (k == s)) e_start++;
        end else if (k < s + tot) begin
          pos = exp_pos(k - s, m);
          if (!pix_valid || col_idx != 6'(pos / 16) || font_x != 4'(pos % 16)) e_body++;
        end else begin
          if (pix_valid) e_end++;
        end
        if (k == s && pix_valid && (col_idx != 0 || font_x != 0)) e_start++;
        @(negedge clk);
      end
      chk(e_start == 0, "R2 R3 R9 window start cycle", e_start, 0);
      chk(e_body == 0, "R5 R6 R7 R9 column sequence", e_body, 0);
      chk(e_end == 0, "R8 window end", e_end, 0);
    end

    // vertical placement, R4 and R10
    begin
      int bad_v = 0;
      int bad_l = 0;
      hstart = 8'd3; wide_mask = '0; vstart = 8'd3;
      pulse_vs();
      for (int L = 0; L < 12; L++) begin
        bit inwin;
        pulse_fb();
        inwin = (L >= 6 && L < 6 + WL);
        if (win_active != inwin) bad_v++;
        if (line_in_win != (inwin ? 10'(L - 6) : 10'd0)) bad_l++;
      end
      chk(bad_v == 0, "R4 window line range", bad_v, 0);
      chk(bad_l == 0, "R10 line in window", bad_l, 0);
    end

    // R11 vsync and flyback on the same edge
    vstart = 8'd0;
    pulse_vs();
    for (int L = 0; L < 6; L++) pulse_fb();
    chk(win_active == 0, "R4 below window before collision", int'(win_active), 0);
    @(negedge clk) begin vsync = 1'b1; hflyback = 1'b1; end
    @(negedge clk) begin vsync = 1'b0; hflyback = 1'b0; end
    chk(win_active == 1, "R11 collision gives line 0 active", int'(win_active), 1);
    chk(line_in_win == 0, "R11 collision line index", int'(line_in_win), 0);

    // R12 flyback in the middle of a running window
    hstart = 8'd3; wide_mask = '0;
    pulse_vs();
    pulse_fb();
    repeat (50) @(negedge clk);
    chk(pix_valid && col_idx == 0 && font_x == 8, "R12 running before cut", int'(font_x), 8);
    pulse_fb();
    chk(!pix_valid, "R12 cut by flyback", int'(pix_valid), 0);
    repeat (42) @(negedge clk);
    chk(pix_valid && col_idx == 0 && font_x == 0, "R12 restart at column 0",
        int'(col_idx) * 16 + int'(font_x), 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule